// File: doc/BRIEF.md
# Gated Programmable Timer Channel

A single 16-bit timer channel for a video-oriented system. A count advances at a rate set by a 2-bit clock-source field. The rate is the bus clock undivided, divided by 16, divided by 256, or one step per horizontal-blank start pulse. A programmable target value and the 16-bit wrap each raise a sticky flag and a one-cycle interrupt pulse when their enable bit is set. On a match the channel either subtracts the target from the count (zero-return) or disarms the target until the next wrap. An optional gate ties the channel to the horizontal- or vertical-blank start/end pulses. The gate can run the count only between start and end, or clear and restart it at the start edge, the end edge or both.

Software reaches four 16-bit registers through a plain valid/write/address/data port: count, mode, target and an optional hold word. Reads return zero in the upper 16 bits. A write to the count, mode or target register takes effect on the next clock edge. In that cycle it takes precedence over the count step and any gate event.

Whether the target may fire is held in a two-state machine. In ARM_LIVE a match can fire. ARM_SPENT is entered by the SPEND transition. SPEND happens on a match, on a count write that lands above the target, and on a target write at or below the current count. ARM_SPENT is left by the RENEW transition. RENEW happens on a wrap, on a count write at or below the target, on a target write above the count, and on a gate-driven reset. When both transitions are requested in one cycle, RENEW wins.

Top module: `blank_gated_timer`

## Requirements
- R1: After reset the count reads 0, the mode reads 0 (clock source 0, stopped), the target reads 0xFFFF and irq is low.
- R2: Address 0 is count, 1 is mode, 2 is target, 3 is hold. Every read has bits 31:16 at zero. A mode read carries the stored bits 9:0, the target-reached flag at bit 10 and the overflow-reached flag at bit 11. With the hold word present, a hold write keeps its low 16 bits for read-back.
- R3: Mode bit 7 runs the channel. Clock-source bits 1:0 select the rate: code 0 is one step per cycle, 1 is one step per 16 cycles, 2 is one step per 256 cycles, and 3 is one step per horizontal-blank start pulse. While bit 7 is clear the count holds.
- R4: When a step makes the count reach or pass an armed target and target-interrupt enable (bit 8) is set, bit 10 sets and irq is high for one cycle after that edge. Without zero-return the count keeps the matched value and the target disarms.
- R5: With zero-return (bit 6) also set, the matching step leaves count+1 minus target in the count, and the target stays armed.
- R6: A match with bit 8 clear disarms the target and sets no flag and no irq.
- R7: A step from 0xFFFF wraps the count to 0 and re-arms the target. Bit 11 and an irq pulse follow only when overflow-interrupt enable (bit 9) is set.
- R8: A mode write stores bits 9:0. Flags at bits 10 and 11 clear only where the written word holds a 1.
- R9: A count write loads the low 16 bits. The target is armed if the new count is at or below the target, and disarmed otherwise.
- R10: A target write loads the low 16 bits. The target is armed only if the new value is above the current count.
- R11: A mode write with gate enable (bit 2) clears the count and bit 7. The exception is gate source (bit 3) 0 = horizontal blank together with clock source 3; in that case the gate is ignored. Gate source 1 is vertical blank.
- R12: Gate mode (bits 5:4) 0 sets bit 7 at a gate start pulse and clears it at a gate end pulse, keeping the count. The step of the end cycle still counts.
- R13: Gate mode 1 clears the count, sets bit 7 and re-arms the target at a start pulse. Mode 2 does this at an end pulse, and mode 3 at both. A gate reset wins over a step in the same cycle.
- R14: In a cycle with a count, mode or target write, the count step and gate pulses are ignored. The prescaler phase is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| hblank_start | input | 1 | Horizontal-blank start pulse |
| hblank_end | input | 1 | Horizontal-blank end pulse |
| vblank_start | input | 1 | Vertical-blank start pulse |
| vblank_end | input | 1 | Vertical-blank end pulse |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The target match and the wrap can fall on the same step. This happens when the count is written to 0xFFFF while the target is 0xFFFF and armed. One step later, both flags must read set, the count must be 0 and a single irq cycle must appear. With zero-return also set, the same setup must instead leave the count at 1 with only the target flag set, because the subtraction removes the wrap. Gate resets on the same edge as a step are judged by the count reading exactly 0 after the pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        CLK_DIV1   = 2'd0,
        CLK_DIV16  = 2'd1,
        CLK_DIV256 = 2'd2,
        CLK_HBLANK = 2'd3
    } clk_src_e;

    typedef enum logic [1:0] {
        GM_LEVEL     = 2'd0,
        GM_RST_START = 2'd1,
        GM_RST_END   = 2'd2,
        GM_RST_BOTH  = 2'd3
    } gate_mode_e;

    typedef enum logic [1:0] {
        REG_COUNT  = 2'd0,
        REG_MODE   = 2'd1,
        REG_TARGET = 2'd2,
        REG_HOLD   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       ovf_ie;
        logic       tgt_ie;
        logic       run;
        logic       zero_ret;
        gate_mode_e gmode;
        logic       gsrc_v;
        logic       gate_en;
        clk_src_e   csrc;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    function automatic logic gate_effective(input mode_t m);
        return m.gate_en && !(!m.gsrc_v && (m.csrc == CLK_HBLANK));
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int MID_LOG2  = 4,
    parameter int SLOW_LOG2 = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  clk_src_e src,
    output logic     tick
);
    localparam int PW = SLOW_LOG2;

    logic [PW-1:0] phase_q;
    logic [PW-1:0] mask;

    always_comb begin
        unique case (src)
            CLK_DIV1:   mask = '0;
            CLK_DIV16:  mask = PW'((1 << MID_LOG2) - 1);
            CLK_DIV256: mask = '1;
            CLK_HBLANK: mask = '0;
        endcase
    end

    assign tick = en && ((phase_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (!rst_n)  phase_q <= '0;
        else if (en) phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/tmr_gate_ctl.sv
module tmr_gate_ctl
    import tmr_pkg::*;
(
    input  mode_t mode,
    input  logic  allow,
    input  logic  hb_start,
    input  logic  hb_end,
    input  logic  vb_start,
    input  logic  vb_end,
    output logic  g_run,
    output logic  g_stop,
    output logic  g_reset
);
    logic live, s_ev, e_ev;

    assign live = allow && gate_effective(mode);
    assign s_ev = live && (mode.gsrc_v ? vb_start : hb_start);
    assign e_ev = live && (mode.gsrc_v ? vb_end : hb_end);

    always_comb begin
        g_run   = 1'b0;
        g_stop  = 1'b0;
        g_reset = 1'b0;
        unique case (mode.gmode)
            GM_LEVEL: begin
                g_run  = s_ev;
                g_stop = e_ev;
            end
            GM_RST_START: g_reset = s_ev;
            GM_RST_END:   g_reset = e_ev;
            GM_RST_BOTH:  g_reset = s_ev | e_ev;
        endcase
    end
endmodule

// File: rtl/tmr_arm_fsm.sv
module tmr_arm_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic renew,
    input  logic spend,
    output logic armed
);
    typedef enum logic {ARM_LIVE, ARM_SPENT} arm_state_e;

    arm_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_LIVE:  if (spend && !renew) state_d = ARM_SPENT;
            ARM_SPENT: if (renew)           state_d = ARM_LIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARM_LIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        armed = (state_q == ARM_LIVE);
    end
endmodule

// File: rtl/blank_gated_timer.sv
module blank_gated_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int BUS_W     = 32,
    parameter int MID_LOG2  = 4,
    parameter int SLOW_LOG2 = 8,
    parameter bit HAS_HOLD  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             hblank_start,
    input  logic             hblank_end,
    input  logic             vblank_start,
    input  logic             vblank_end,
    output logic             irq
);
    localparam int FLAG_T_BIT = MODE_W;
    localparam int FLAG_O_BIT = MODE_W + 1;

    logic [CNT_W-1:0] cnt_q, cnt_d, tgt_q, tgt_d, hold_q, wval;
    mode_t            mode_q, mode_d, mode_w;
    logic             flag_t_q, flag_t_d, flag_o_q, flag_o_d, irq_q, irq_d;
    logic             wr, wr_cnt, wr_mode, wr_tgt, wr_hold, blk;
    logic             pre_en, pre_tick, step, armed, renew, spend;
    logic             g_run, g_stop, g_reset, run_now;
    logic [CNT_W:0]   inc, work;
    logic             unused_hi;

    assign wval      = bus_wdata[CNT_W-1:0];
    assign unused_hi = ^bus_wdata[BUS_W-1:CNT_W];
    assign mode_w    = mode_t'(bus_wdata[MODE_W-1:0]);
    assign wr        = bus_valid && bus_write;
    assign wr_cnt    = wr && (bus_addr == REG_COUNT);
    assign wr_mode   = wr && (bus_addr == REG_MODE);
    assign wr_tgt    = wr && (bus_addr == REG_TARGET);
    assign wr_hold   = wr && (bus_addr == REG_HOLD);
    assign blk       = wr_cnt || wr_mode || wr_tgt;
    assign run_now   = mode_q.run;
    assign pre_en    = mode_q.run && (mode_q.csrc != CLK_HBLANK);
    assign step      = !blk && mode_q.run &&
                       ((mode_q.csrc == CLK_HBLANK) ? hblank_start : pre_tick);
    assign inc       = {1'b0, cnt_q} + 1'b1;

    tmr_prescaler #(.MID_LOG2(MID_LOG2), .SLOW_LOG2(SLOW_LOG2)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(pre_en), .src(mode_q.csrc), .tick(pre_tick)
    );

    tmr_gate_ctl u_gate (
        .mode(mode_q), .allow(!blk),
        .hb_start(hblank_start), .hb_end(hblank_end),
        .vb_start(vblank_start), .vb_end(vblank_end),
        .g_run(g_run), .g_stop(g_stop), .g_reset(g_reset)
    );

    tmr_arm_fsm u_arm (
        .clk(clk), .rst_n(rst_n), .renew(renew), .spend(spend), .armed(armed)
    );

    always_comb begin
        cnt_d    = cnt_q;
        tgt_d    = tgt_q;
        mode_d   = mode_q;
        flag_t_d = flag_t_q;
        flag_o_d = flag_o_q;
        irq_d    = 1'b0;
        renew    = 1'b0;
        spend    = 1'b0;
        work     = inc;
        if (wr_cnt) begin
            cnt_d = wval;
            if (wval > tgt_q) spend = 1'b1;
            else              renew = 1'b1;
        end else if (wr_tgt) begin
            tgt_d = wval;
            if (wval <= cnt_q) spend = 1'b1;
            else               renew = 1'b1;
        end else if (wr_mode) begin
            flag_t_d = flag_t_q && !bus_wdata[FLAG_T_BIT];
            flag_o_d = flag_o_q && !bus_wdata[FLAG_O_BIT];
            mode_d   = mode_w;
            if (gate_effective(mode_w)) begin
                mode_d.run = 1'b0;
                cnt_d      = '0;
            end
        end else if (g_reset) begin
            cnt_d      = '0;
            mode_d.run = 1'b1;
            renew      = 1'b1;
        end else begin
            if (g_stop)     mode_d.run = 1'b0;
            else if (g_run) mode_d.run = 1'b1;
            if (step) begin
                if (armed && (inc >= {1'b0, tgt_q})) begin
                    if (mode_q.tgt_ie) begin
                        flag_t_d = 1'b1;
                        irq_d    = 1'b1;
                        if (mode_q.zero_ret) work = inc - {1'b0, tgt_q};
                        else                 spend = 1'b1;
                    end else begin
                        spend = 1'b1;
                    end
                end
                if (work[CNT_W]) begin
                    renew = 1'b1;
                    if (mode_q.ovf_ie) begin
                        flag_o_d = 1'b1;
                        irq_d    = 1'b1;
                    end
                end
                cnt_d = work[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            tgt_q    <= '1;
            mode_q   <= '0;
            flag_t_q <= 1'b0;
            flag_o_q <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            cnt_q    <= cnt_d;
            tgt_q    <= tgt_d;
            mode_q   <= mode_d;
            flag_t_q <= flag_t_d;
            flag_o_q <= flag_o_d;
            irq_q    <= irq_d;
        end
    end

    generate
        if (HAS_HOLD) begin : g_hold
            always_ff @(posedge clk) begin
                if (!rst_n)       hold_q <= '0;
                else if (wr_hold) hold_q <= wval;
            end
        end else begin : g_nohold
            assign hold_q = '0;
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_COUNT:  bus_rdata[CNT_W-1:0]    = cnt_q;
            REG_MODE:   bus_rdata[FLAG_O_BIT:0] = {flag_o_q, flag_t_q, mode_q};
            REG_TARGET: bus_rdata[CNT_W-1:0]    = tgt_q;
            REG_HOLD:   bus_rdata[CNT_W-1:0]    = hold_q;
        endcase
    end

    assign irq = irq_q;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic        bus_write,
    input logic [1:0]  bus_addr,
    input logic [15:0] wdata_lo,
    input logic [15:0] rdata_hi,
    input logic        irq,
    input logic [15:0] cnt,
    input logic [15:0] tgt,
    input logic        run,
    input logic        flag_t,
    input logic        flag_o,
    input logic        blk,
    input logic        g_reset
);
    logic wr_cnt, wr_tgt, wr_mode, gate_w;

    assign wr_cnt  = bus_valid && bus_write && (bus_addr == 2'd0);
    assign wr_mode = bus_valid && bus_write && (bus_addr == 2'd1);
    assign wr_tgt  = bus_valid && bus_write && (bus_addr == 2'd2);
    assign gate_w  = wdata_lo[2] && !(!wdata_lo[3] && (wdata_lo[1:0] == 2'b11));

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_hi == 16'h0);

    a_r9_count_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt == $past(wdata_lo)));

    a_r10_target_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tgt |=> (tgt == $past(wdata_lo)));

    a_r4_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_t || flag_o));

    a_r3_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !blk && !g_reset) |=> $stable(cnt));

    a_r11_gate_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode && gate_w) |=> (!run && (cnt == 16'h0)));
endmodule

bind blank_gated_timer tmr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .wdata_lo(bus_wdata[15:0]), .rdata_hi(bus_rdata[31:16]),
    .irq(irq), .cnt(cnt_q), .tgt(tgt_q), .run(run_now), .flag_t(flag_t_q),
    .flag_o(flag_o_q), .blk(blk), .g_reset(g_reset)
);

// File: tb/blank_gated_timer_tb_top.sv
module blank_gated_timer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        hb_s = 1'b0, hb_e = 1'b0, vb_s = 1'b0, vb_e = 1'b0;
    logic        irq;
    int          checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blank_gated_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hblank_start(hb_s), .hblank_end(hb_e), .vblank_start(vb_s),
        .vblank_end(vb_e), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(input int which);
        hb_s = (which == 0); hb_e = (which == 1);
        vb_s = (which == 2); vb_e = (which == 3);
        @(posedge clk);
        @(negedge clk);
        hb_s = 1'b0; hb_e = 1'b0; vb_s = 1'b0; vb_e = 1'b0;
    endtask

    task automatic expect_reg(input string tag, input logic [1:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic t_reset();
        expect_reg("R1 count", 2'd0, 32'h0);
        expect_reg("R1 mode", 2'd1, 32'h0);
        expect_reg("R1 target", 2'd2, 32'h0000FFFF);
        check("R1 irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_rates();
        logic [31:0] c;
        step(20);
        expect_reg("R3 stopped holds", 2'd0, 32'h0);
        wr(2'd1, 32'h80);
        rd(2'd0, c); step(10);
        expect_reg("R3 div1", 2'd0, c + 10);
        wr(2'd1, 32'h81);
        rd(2'd0, c); step(256);
        expect_reg("R3 div16", 2'd0, c + 16);
        wr(2'd1, 32'h82);
        rd(2'd0, c); step(512);
        expect_reg("R3 div256", 2'd0, c + 2);
        wr(2'd1, 32'h0);
    endtask

    task automatic t_hblank_clock();
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h83);
        step(5);
        expect_reg("R3 hblank no pulse", 2'd0, 32'h0);
        pulse(0); pulse(0); pulse(0);
        expect_reg("R3 hblank three", 2'd0, 32'h3);
        pulse(1); pulse(2); pulse(3);
        expect_reg("R3 other pulses", 2'd0, 32'h3);
        wr(2'd1, 32'h87);
        expect_reg("R11 ignored gate mode", 2'd1, 32'h87);
        expect_reg("R11 ignored gate count", 2'd0, 32'h3);
        pulse(0);
        expect_reg("R11 ignored gate counts", 2'd0, 32'h4);
    endtask

    task automatic t_target();
        wr(2'd1, 32'hC00);
        wr(2'd0, 32'h10);
        wr(2'd2, 32'h14);
        wr(2'd1, 32'h180);
        step(3);
        expect_reg("R4 before match", 2'd0, 32'h13);
        check("R4 irq before", {31'h0, irq}, 32'h0);
        step(1);
        expect_reg("R4 match count", 2'd0, 32'h14);
        check("R4 irq at match", {31'h0, irq}, 32'h1);
        expect_reg("R4 flag", 2'd1, 32'h580);
        step(1);
        check("R4 irq one cycle", {31'h0, irq}, 32'h0);
        expect_reg("R4 keeps counting", 2'd0, 32'h15);
        step(3);
        check("R4 disarmed no refire", {31'h0, irq}, 32'h0);
        wr(2'd1, 32'h180);
        expect_reg("R8 zero keeps flag", 2'd1, 32'h580);
        wr(2'd1, 32'h400);
        expect_reg("R8 one clears flag", 2'd1, 32'h0);
    endtask

    task automatic t_zero_return();
        wr(2'd0, 32'h0);
        wr(2'd2, 32'h5);
        wr(2'd1, 32'h1C0);
        step(4);
        expect_reg("R5 before", 2'd0, 32'h4);
        step(1);
        expect_reg("R5 returned", 2'd0, 32'h0);
        check("R5 irq", {31'h0, irq}, 32'h1);
        step(5);
        check("R5 still armed", {31'h0, irq}, 32'h1);
        wr(2'd1, 32'h400);
    endtask

    task automatic t_silent();
        wr(2'd0, 32'h0);
        wr(2'd2, 32'h3);
        wr(2'd1, 32'h80);
        for (int i = 0; i < 6; i++) begin
            step(1);
            check("R6 no irq", {31'h0, irq}, 32'h0);
        end
        expect_reg("R6 count", 2'd0, 32'h6);
        expect_reg("R6 no flag", 2'd1, 32'h80);
        wr(2'd1, 32'h0);
    endtask

    task automatic t_overflow();
        wr(2'd0, 32'hFFFD);
        wr(2'd2, 32'h2);
        wr(2'd1, 32'h380);
        step(2);
        check("R10 late target silent", {31'h0, irq}, 32'h0);
        expect_reg("R7 pre wrap", 2'd0, 32'hFFFF);
        step(1);
        expect_reg("R7 wrapped", 2'd0, 32'h0);
        check("R7 irq", {31'h0, irq}, 32'h1);
        expect_reg("R7 flag", 2'd1, 32'hB80);
        step(2);
        check("R7 rearmed match", {31'h0, irq}, 32'h1);
        expect_reg("R7 both flags", 2'd1, 32'hF80);
        wr(2'd1, 32'hC00);
    endtask

    task automatic t_coincide();
        wr(2'd0, 32'h0);
        wr(2'd2, 32'hFFFF);
        wr(2'd0, 32'hFFFF);
        wr(2'd1, 32'h380);
        step(1);
        expect_reg("R7 coincide count", 2'd0, 32'h0);
        check("R4 coincide irq", {31'h0, irq}, 32'h1);
        expect_reg("R4 coincide flags", 2'd1, 32'hF80);
        wr(2'd1, 32'hC00);
        wr(2'd0, 32'h0);
        wr(2'd2, 32'hFFFF);
        wr(2'd0, 32'hFFFF);
        wr(2'd1, 32'h3C0);
        step(1);
        expect_reg("R5 coincide count", 2'd0, 32'h1);
        expect_reg("R5 coincide flags", 2'd1, 32'h7C0);
        wr(2'd1, 32'hC00);
    endtask

    task automatic t_gate_level();
        wr(2'd0, 32'h55);
        wr(2'd1, 32'h8C);
        expect_reg("R11 gate stops", 2'd1, 32'h0C);
        expect_reg("R11 gate clears", 2'd0, 32'h0);
        pulse(0);
        expect_reg("R12 wrong source", 2'd0, 32'h0);
        pulse(2);
        expect_reg("R12 start runs", 2'd1, 32'h8C);
        step(4);
        expect_reg("R12 counting", 2'd0, 32'h4);
        pulse(3);
        expect_reg("R12 end cycle counts", 2'd0, 32'h5);
        expect_reg("R12 end stops", 2'd1, 32'h0C);
        step(3);
        expect_reg("R12 frozen", 2'd0, 32'h5);
    endtask

    task automatic t_gate_modes();
        wr(2'd1, 32'h2C);
        pulse(2);
        expect_reg("R13 mode2 start idle", 2'd1, 32'h2C);
        pulse(3);
        expect_reg("R13 mode2 end runs", 2'd1, 32'hAC);
        step(3);
        expect_reg("R13 mode2 count", 2'd0, 32'h3);
        pulse(3);
        expect_reg("R13 mode2 reset", 2'd0, 32'h0);
        wr(2'd1, 32'h1C);
        pulse(3);
        expect_reg("R13 mode1 end idle", 2'd1, 32'h1C);
        pulse(2);
        step(3);
        expect_reg("R13 mode1 count", 2'd0, 32'h3);
        pulse(3);
        expect_reg("R13 mode1 end ignored", 2'd0, 32'h4);
        pulse(2);
        expect_reg("R13 mode1 restart", 2'd0, 32'h0);
        wr(2'd1, 32'h134);
        wr(2'd2, 32'h2);
        wr(2'd0, 32'h5);
        pulse(0);
        expect_reg("R13 mode3 start", 2'd0, 32'h0);
        step(1);
        check("R13 no early irq", {31'h0, irq}, 32'h0);
        step(1);
        check("R13 rearmed irq", {31'h0, irq}, 32'h1);
        pulse(1);
        expect_reg("R13 mode3 end reset", 2'd0, 32'h0);
        wr(2'd1, 32'hC00);
    endtask

    task automatic t_precedence();
        logic [31:0] c;
        wr(2'd1, 32'h80);
        rd(2'd0, c);
        wr(2'd2, 32'h7777);
        expect_reg("R14 write drops step", 2'd0, c);
        step(1);
        expect_reg("R14 step resumes", 2'd0, c + 1);
        wr(2'd1, 32'h0);
        wr(2'd0, 32'hABCD1234);
        expect_reg("R9 low half", 2'd0, 32'h1234);
        wr(2'd3, 32'h1234ABCD);
        expect_reg("R2 hold", 2'd3, 32'hABCD);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rates();
        t_hblank_clock();
        t_target();
        t_zero_return();
        t_silent();
        t_overflow();
        t_coincide();
        t_gate_level();
        t_gate_modes();
        t_precedence();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule